// File: doc/BRIEF.md
# MMU control register file

This block holds the control registers of a paged memory-management unit and carries out the side effects that writing them has. A register-move port presents one request at a time: a register index, a transfer size, a direction and up to 64 bits of write data. Reads return the selected register, zero-extended, one cycle after the request is taken. Writes to the three root pointers and to the translation control register have side effects:

- a lookup in a small table of recent CPU root pointers;
- invalidation of entries in a tag model of the address translation cache (ATC);
- a field consistency check.

The request port uses valid/ready handshaking. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. The requester must hold every request field stable while `req_valid` is high and `req_ready` is low. `req_ready` drops for exactly one cycle after a write that has a side effect. The ATC itself is only a bank of per-entry valid bits with tags. It is loaded through a plain fill port and can be observed on `atc_valid`. Trap, size-error and configuration-error outputs are single-cycle pulses.

Top module: `mmu_ctlreg_file`

## Requirements
- R1: A request taken while `supervisor` is low gives a `priv_trap` pulse in the next cycle. It gives no `rd_valid` and changes no register, root-table or ATC state.
- R2: Register indices and widths: 0 CPU root, 1 supervisor root, 2 DMA root (64 bits each), 3 translation control (32 bits), 4 to 8 (16 bits), 9 to 11 (8 bits). Size code 0 is byte, 1 word, 2 long, 3 quad. A correctly sized read gives `rd_valid` with zero-extended data one cycle after it is taken. A read after a write returns the written value.
- R3: A size code that does not match the selected register, or an index of 12 to 15, gives a `size_err` pulse in the next cycle and changes no state.
- R4: Writing the CPU root with a value already held in the 8-entry root table is a hit. `root_slot` then shows the matching entry, and no entry is replaced and no ATC entry is invalidated.
- R5: A CPU root write that misses replaces the table entry in round-robin order, starting at 0 after reset and wrapping after 7. `root_slot` then shows that entry. Every valid, non-global ATC entry with source CPU and that root index is invalidated in the same cycle.
- R6: Writing the supervisor root invalidates every ATC entry with source supervisor, global entries included.
- R7: Writing the DMA root invalidates every ATC entry with source DMA, global entries included.
- R8: Translation control layout: enable is bit 31. The page-size field is at [23:20], the initial shift at [19:16], and the four table-index widths at [15:12], [11:8], [7:4] and [3:0]. A write that sets enable while it is clear passes the check only if the six fields sum to 32. On a failure the value is stored with enable cleared and `cfg_err` pulses in the next cycle.
- R9: A translation control write made while enable is already set is stored as written, with no check and no `cfg_err`.
- R10: After reset `req_ready` is high and `busy`, the pulses, `atc_valid` and `root_slot` are zero. A taken write to index 0 to 3 sets `busy` high and `req_ready` low for exactly the next cycle.
- R11: A request presented while `req_ready` is low is not taken. It is taken on the first edge with `req_ready` high.
- R12: A fill with `atc_fill_en` high sets the valid bit of the addressed ATC entry and loads its global bit, source (0 CPU, 1 supervisor, 2 DMA) and root index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Requester is in supervisor state |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_index | input | 4 | Register index |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | 64 | Write data, low-aligned |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data, zero-extended |
| priv_trap | output | 1 | Privilege trap pulse |
| size_err | output | 1 | Size or index error pulse |
| cfg_err | output | 1 | Consistency check failure pulse |
| busy | output | 1 | Side-effect cycle in progress |
| atc_fill_en | input | 1 | Load one ATC entry |
| atc_fill_slot | input | 4 | ATC entry to load |
| atc_fill_global | input | 1 | Global bit for the fill |
| atc_fill_src | input | 2 | Source root for the fill |
| atc_fill_root | input | 3 | Root-table index for the fill |
| atc_valid | output | 16 | Valid bits of all ATC entries |
| root_slot | output | 3 | Root-table entry of the current CPU root |

## Verification
The bench builds the block with its default sizes: 16 ATC entries and an 8-entry root table. With only eight entries, a run of distinct CPU root writes wraps the round-robin victim in a few cycles. That lets the bench show that a value once held, and later evicted, misses again. Sixteen ATC entries leave enough room to hold global and non-global entries of all three sources at once. A single root write can then be seen to clear exactly its own subset on `atc_valid`.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int W_QUAD = 64;
  localparam int W_LONG = 32;
  localparam int W_WORD = 16;
  localparam int W_BYTE = 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SZ_QUAD = 2'd3;

  localparam logic [1:0] SRC_CPU = 2'd0;
  localparam logic [1:0] SRC_SUP = 2'd1;
  localparam logic [1:0] SRC_DMA = 2'd2;

  localparam logic [3:0] RIX_CROOT = 4'd0;
  localparam logic [3:0] RIX_SROOT = 4'd1;
  localparam logic [3:0] RIX_DROOT = 4'd2;
  localparam logic [3:0] RIX_XCTL  = 4'd3;
  localparam logic [3:0] RIX_BKCTL = 4'd4;
  localparam logic [3:0] RIX_BKDAT = 4'd5;
  localparam logic [3:0] RIX_ACCTL = 4'd6;
  localparam logic [3:0] RIX_STAT  = 4'd7;
  localparam logic [3:0] RIX_CSTAT = 4'd8;
  localparam logic [3:0] RIX_CURLV = 4'd9;
  localparam logic [3:0] RIX_VALLV = 4'd10;
  localparam logic [3:0] RIX_STKCH = 4'd11;

  localparam int XCTL_EN_BIT = 31;
  localparam int XCTL_SUM    = 32;

  // {index exists, required size code}
  function automatic logic [2:0] reg_width_code(input logic [3:0] ix);
    case (ix)
      RIX_CROOT, RIX_SROOT, RIX_DROOT: return {1'b1, SZ_QUAD};
      RIX_XCTL:                        return {1'b1, SZ_LONG};
      RIX_BKCTL, RIX_BKDAT, RIX_ACCTL,
      RIX_STAT, RIX_CSTAT:             return {1'b1, SZ_WORD};
      RIX_CURLV, RIX_VALLV, RIX_STKCH: return {1'b1, SZ_BYTE};
      default:                         return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/mmu_root_table.sv
module mmu_root_table #(
  parameter int ENTRIES = 8,
  parameter int VAL_W   = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look_en,
  input  logic [VAL_W-1:0] look_val,
  output logic             repl_en,
  output logic [IDX_W-1:0] victim,
  output logic [IDX_W-1:0] cur_slot
);
  logic [VAL_W-1:0] ent_val [ENTRIES];
  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_val[g] == look_val);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit     = |match;
  assign repl_en = look_en && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_val[i] <= '0;
      ent_vld  <= '0;
      victim   <= '0;
      cur_slot <= '0;
    end else if (look_en) begin
      if (hit) begin
        cur_slot <= hit_idx;
      end else begin
        ent_val[victim] <= look_val;
        ent_vld[victim] <= 1'b1;
        cur_slot        <= victim;
        victim          <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmu_atc_tags.sv
module mmu_atc_tags
  import mmu_ctl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int RPT_W   = 3,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [SLOT_W-1:0]  fill_slot,
  input  logic               fill_global,
  input  logic [1:0]         fill_src,
  input  logic [RPT_W-1:0]   fill_root,
  input  logic               inv_cpu_en,
  input  logic [RPT_W-1:0]   inv_cpu_root,
  input  logic               inv_sup_en,
  input  logic               inv_dma_en,
  output logic [ENTRIES-1:0] valid_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             glb;
    logic [1:0]       src;
    logic [RPT_W-1:0] root;
    logic             kill;
    logic             load;

    assign kill = (inv_cpu_en && src == SRC_CPU && !glb && root == inv_cpu_root)
               || (inv_sup_en && src == SRC_SUP)
               || (inv_dma_en && src == SRC_DMA);
    assign load = fill_en && (fill_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        glb          <= 1'b0;
        src          <= SRC_CPU;
        root         <= '0;
      end else if (kill) begin
        valid_vec[g] <= 1'b0;
      end else if (load) begin
        valid_vec[g] <= 1'b1;
        glb          <= fill_global;
        src          <= fill_src;
        root         <= fill_root;
      end
    end
  end
endmodule

// File: rtl/mmu_xctl_check.sv
module mmu_xctl_check
  import mmu_ctl_pkg::*;
(
  input  logic [23:0] fields,
  output logic        ok
);
  logic [6:0] sum;
  always_comb begin
    sum = '0;
    for (int f = 0; f < 6; f++) sum = sum + 7'(fields[f*4 +: 4]);
  end
  assign ok = (sum == 7'(XCTL_SUM));
endmodule

// File: rtl/mmu_ctlreg_file.sv
module mmu_ctlreg_file
  import mmu_ctl_pkg::*;
#(
  parameter int ATC_ENTRIES = 16,
  parameter int RPT_ENTRIES = 8,
  localparam int SLOT_W     = $clog2(ATC_ENTRIES),
  localparam int RPT_W      = $clog2(RPT_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   supervisor,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [3:0]             req_index,
  input  logic [1:0]             req_size,
  input  logic [W_QUAD-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [W_QUAD-1:0]      rd_data,
  output logic                   priv_trap,
  output logic                   size_err,
  output logic                   cfg_err,
  output logic                   busy,
  input  logic                   atc_fill_en,
  input  logic [SLOT_W-1:0]      atc_fill_slot,
  input  logic                   atc_fill_global,
  input  logic [1:0]             atc_fill_src,
  input  logic [RPT_W-1:0]       atc_fill_root,
  output logic [ATC_ENTRIES-1:0] atc_valid,
  output logic [RPT_W-1:0]       root_slot
);
  logic [W_QUAD-1:0] croot_q, sroot_q, droot_q;
  logic [W_LONG-1:0] xctl_q;
  logic [W_WORD-1:0] bkctl_q, bkdat_q, acctl_q, stat_q, cstat_q;
  logic [W_BYTE-1:0] curlv_q, vallv_q, stkch_q;

  logic              accept, width_ok, wr_ok, rd_ok, side_fx;
  logic              xctl_ok, en_rise, xctl_bad;
  logic [2:0]        wcode;
  logic [W_QUAD-1:0] rd_mux;
  logic              repl_en;
  logic [RPT_W-1:0]  victim;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign wcode     = reg_width_code(req_index);
  assign width_ok  = wcode[2] && (wcode[1:0] == req_size);
  assign wr_ok     = accept && supervisor && width_ok && req_write;
  assign rd_ok     = accept && supervisor && width_ok && !req_write;
  assign side_fx   = wr_ok && (req_index <= RIX_XCTL);
  assign en_rise   = req_wdata[XCTL_EN_BIT] && !xctl_q[XCTL_EN_BIT];
  assign xctl_bad  = wr_ok && (req_index == RIX_XCTL) && en_rise && !xctl_ok;

  mmu_xctl_check u_xchk (.fields(req_wdata[23:0]), .ok(xctl_ok));

  mmu_root_table #(.ENTRIES(RPT_ENTRIES), .VAL_W(W_QUAD)) u_rtab (
    .clk(clk), .rst_n(rst_n),
    .look_en(wr_ok && req_index == RIX_CROOT), .look_val(req_wdata),
    .repl_en(repl_en), .victim(victim), .cur_slot(root_slot)
  );

  mmu_atc_tags #(.ENTRIES(ATC_ENTRIES), .RPT_W(RPT_W)) u_atc (
    .clk(clk), .rst_n(rst_n),
    .fill_en(atc_fill_en), .fill_slot(atc_fill_slot), .fill_global(atc_fill_global),
    .fill_src(atc_fill_src), .fill_root(atc_fill_root),
    .inv_cpu_en(repl_en), .inv_cpu_root(victim),
    .inv_sup_en(wr_ok && req_index == RIX_SROOT),
    .inv_dma_en(wr_ok && req_index == RIX_DROOT),
    .valid_vec(atc_valid)
  );

  always_comb begin
    rd_mux = '0;
    case (req_index)
      RIX_CROOT: rd_mux = croot_q;
      RIX_SROOT: rd_mux = sroot_q;
      RIX_DROOT: rd_mux = droot_q;
      RIX_XCTL:  rd_mux = W_QUAD'(xctl_q);
      RIX_BKCTL: rd_mux = W_QUAD'(bkctl_q);
      RIX_BKDAT: rd_mux = W_QUAD'(bkdat_q);
      RIX_ACCTL: rd_mux = W_QUAD'(acctl_q);
      RIX_STAT:  rd_mux = W_QUAD'(stat_q);
      RIX_CSTAT: rd_mux = W_QUAD'(cstat_q);
      RIX_CURLV: rd_mux = W_QUAD'(curlv_q);
      RIX_VALLV: rd_mux = W_QUAD'(vallv_q);
      RIX_STKCH: rd_mux = W_QUAD'(stkch_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      croot_q <= '0; sroot_q <= '0; droot_q <= '0; xctl_q <= '0;
      bkctl_q <= '0; bkdat_q <= '0; acctl_q <= '0; stat_q <= '0; cstat_q <= '0;
      curlv_q <= '0; vallv_q <= '0; stkch_q <= '0;
    end else if (wr_ok) begin
      case (req_index)
        RIX_CROOT: croot_q <= req_wdata;
        RIX_SROOT: sroot_q <= req_wdata;
        RIX_DROOT: droot_q <= req_wdata;
        RIX_XCTL: begin
          xctl_q <= req_wdata[W_LONG-1:0];
          if (xctl_bad) xctl_q[XCTL_EN_BIT] <= 1'b0;
        end
        RIX_BKCTL: bkctl_q <= req_wdata[W_WORD-1:0];
        RIX_BKDAT: bkdat_q <= req_wdata[W_WORD-1:0];
        RIX_ACCTL: acctl_q <= req_wdata[W_WORD-1:0];
        RIX_STAT:  stat_q  <= req_wdata[W_WORD-1:0];
        RIX_CSTAT: cstat_q <= req_wdata[W_WORD-1:0];
        RIX_CURLV: curlv_q <= req_wdata[W_BYTE-1:0];
        RIX_VALLV: vallv_q <= req_wdata[W_BYTE-1:0];
        RIX_STKCH: stkch_q <= req_wdata[W_BYTE-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      priv_trap <= 1'b0;
      size_err  <= 1'b0;
      cfg_err   <= 1'b0;
      busy      <= 1'b0;
    end else begin
      rd_valid  <= rd_ok;
      if (rd_ok) rd_data <= rd_mux;
      priv_trap <= accept && !supervisor;
      size_err  <= accept && supervisor && !width_ok;
      cfg_err   <= xctl_bad;
      busy      <= side_fx;
    end
  end
endmodule

// File: rtl/mmu_ctlreg_chk.sv
module mmu_ctlreg_chk #(
  parameter int ATC_ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   supervisor,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [3:0]             req_index,
  input logic                   rd_valid,
  input logic                   priv_trap,
  input logic                   size_err,
  input logic                   cfg_err,
  input logic                   busy,
  input logic                   atc_fill_en,
  input logic [ATC_ENTRIES-1:0] atc_valid
);
  logic take;
  assign take = req_valid && req_ready;

  assert_user_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !supervisor |=> priv_trap && !rd_valid);

  assert_user_no_atc_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !supervisor && !atc_fill_en |=> $stable(atc_valid));

  assert_bad_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && supervisor && req_index > 4'd11 |=> size_err && !rd_valid);

  assert_read_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && supervisor && !req_write |=> rd_valid || size_err);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, priv_trap, size_err}));

  assert_busy_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_cfg_with_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> busy && !size_err);
endmodule

bind mmu_ctlreg_file mmu_ctlreg_chk #(.ATC_ENTRIES(ATC_ENTRIES)) i_chk (
  .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_index(req_index),
  .rd_valid(rd_valid), .priv_trap(priv_trap), .size_err(size_err),
  .cfg_err(cfg_err), .busy(busy), .atc_fill_en(atc_fill_en), .atc_valid(atc_valid)
);

// File: tb/test_mmu_ctlreg_file.sv
`timescale 1ns/1ps
module test_mmu_ctlreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supervisor = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_index = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        priv_trap, size_err, cfg_err, busy;
  logic        atc_fill_en = 1'b0;
  logic [3:0]  atc_fill_slot = '0;
  logic        atc_fill_global = 1'b0;
  logic [1:0]  atc_fill_src = '0;
  logic [2:0]  atc_fill_root = '0;
  logic [15:0] atc_valid;
  logic [2:0]  root_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mmu_ctlreg_file i_mmu_ctlreg_file (
    .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_index(req_index),
    .req_size(req_size), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .priv_trap(priv_trap), .size_err(size_err),
    .cfg_err(cfg_err), .busy(busy), .atc_fill_en(atc_fill_en),
    .atc_fill_slot(atc_fill_slot), .atc_fill_global(atc_fill_global),
    .atc_fill_src(atc_fill_src), .atc_fill_root(atc_fill_root),
    .atc_valid(atc_valid), .root_slot(root_slot)
  );

  localparam logic [1:0] K_RD = 2'd0, K_TRAP = 2'd1, K_SZ = 2'd2, K_WR = 2'd3;
  localparam int NVEC = 14;
  // {supervisor, write, index, size, wdata, kind, expected read data}
  localparam logic [137:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd4,  2'd1, 64'h1234, K_WR,   64'h0},
    {1'b1, 1'b0, 4'd4,  2'd1, 64'h0,    K_RD,   64'h1234},
    {1'b0, 1'b0, 4'd4,  2'd1, 64'h0,    K_TRAP, 64'h0},
    {1'b0, 1'b1, 4'd4,  2'd1, 64'hFFFF, K_TRAP, 64'h0},
    {1'b1, 1'b0, 4'd4,  2'd1, 64'h0,    K_RD,   64'h1234},
    {1'b1, 1'b1, 4'd9,  2'd0, 64'hA5,   K_WR,   64'h0},
    {1'b1, 1'b1, 4'd9,  2'd1, 64'h5A5A, K_SZ,   64'h0},
    {1'b1, 1'b0, 4'd9,  2'd0, 64'h0,    K_RD,   64'hA5},
    {1'b1, 1'b0, 4'd13, 2'd0, 64'h0,    K_SZ,   64'h0},
    {1'b1, 1'b1, 4'd11, 2'd0, 64'hFF3C, K_WR,   64'h0},
    {1'b1, 1'b0, 4'd11, 2'd0, 64'h0,    K_RD,   64'h3C},
    {1'b1, 1'b0, 4'd8,  2'd1, 64'h0,    K_RD,   64'h0},
    {1'b1, 1'b1, 4'd6,  2'd2, 64'h77,   K_SZ,   64'h0},
    {1'b1, 1'b0, 4'd3,  2'd2, 64'h0,    K_RD,   64'h0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Returns at the falling edge after acceptance, when the registered outcome is visible.
  task automatic req(input logic sup, input logic wr, input logic [3:0] ix,
                     input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    supervisor = sup; req_write = wr; req_index = ix; req_size = sz; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    supervisor = 1'b1;
  endtask

  task automatic fill(input logic [3:0] s, input logic g, input logic [1:0] src,
                      input logic [2:0] rt);
    @(negedge clk);
    atc_fill_en = 1'b1; atc_fill_slot = s; atc_fill_global = g;
    atc_fill_src = src; atc_fill_root = rt;
    @(negedge clk);
    atc_fill_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] ix, input logic [1:0] sz,
                        input logic [63:0] exp);
    req(1'b1, 1'b0, ix, sz, 64'h0);
    chk(tag, {63'h0, rd_valid}, 64'h1);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset ready/busy", {62'h0, req_ready, busy}, 64'h2);
    chk("R10 reset pulses", {61'h0, priv_trap, size_err, cfg_err}, 64'h0);
    chk("R10 reset atc", {48'h0, atc_valid}, 64'h0);
    chk("R10 reset root_slot", {61'h0, root_slot}, 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [137:0] e;
      logic [1:0]   k;
      e = VEC[v];
      k = e[65:64];
      req(e[137], e[136], e[135:132], e[131:130], e[129:66]);
      chk(k == K_TRAP ? "R1 vector" : (k == K_SZ ? "R3 vector" : "R2 vector"),
          {60'h0, rd_valid, priv_trap, size_err, cfg_err},
          {60'h0, k == K_RD, k == K_TRAP, k == K_SZ, 1'b0});
      if (k == K_RD) chk("R2 vector data", rd_data, e[63:0]);
    end

    // R12 ATC fills: src 0 CPU, 1 supervisor, 2 DMA
    fill(4'd0, 1'b0, 2'd0, 3'd0);
    fill(4'd1, 1'b1, 2'd0, 3'd0);
    fill(4'd2, 1'b0, 2'd0, 3'd1);
    fill(4'd3, 1'b0, 2'd1, 3'd0);
    fill(4'd4, 1'b1, 2'd1, 3'd0);
    fill(4'd5, 1'b0, 2'd2, 3'd0);
    fill(4'd6, 1'b1, 2'd2, 3'd0);
    chk("R12 fill", {48'h0, atc_valid}, 64'h7F);

    // R5 first miss -> victim 0
    req(1'b1, 1'b1, 4'd0, 2'd3, 64'hAAAA_0000_0000_0001);
    chk("R10 busy after root write", {62'h0, busy, req_ready}, 64'h2);
    chk("R5 miss victim 0 invalidation", {48'h0, atc_valid}, 64'h7E);
    chk("R5 root_slot 0", {61'h0, root_slot}, 64'h0);
    @(negedge clk);
    chk("R10 busy drops", {62'h0, busy, req_ready}, 64'h1);
    req(1'b1, 1'b1, 4'd0, 2'd3, 64'hBBBB_0000_0000_0002);
    chk("R5 miss victim 1 invalidation", {48'h0, atc_valid}, 64'h7A);
    chk("R5 root_slot 1", {61'h0, root_slot}, 64'h1);
    // R4 hit
    req(1'b1, 1'b1, 4'd0, 2'd3, 64'hAAAA_0000_0000_0001);
    chk("R4 hit root_slot", {61'h0, root_slot}, 64'h0);
    chk("R4 hit no invalidation", {48'h0, atc_valid}, 64'h7A);
    rd_chk("R2 CPU root read", 4'd0, 2'd3, 64'hAAAA_0000_0000_0001);

    // R6 supervisor root write, then R11 back-pressure on the following read
    @(negedge clk);
    supervisor = 1'b1; req_write = 1'b1; req_index = 4'd1; req_size = 2'd3;
    req_wdata = 64'h5555_6666_7777_8888; req_valid = 1'b1;
    @(negedge clk);
    req_write = 1'b0;
    chk("R6 sup invalidation", {48'h0, atc_valid}, 64'h62);
    chk("R11 ready low", {63'h0, req_ready}, 64'h0);
    @(negedge clk);
    chk("R11 held request not taken", {63'h0, rd_valid}, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 taken after ready", {63'h0, rd_valid}, 64'h1);
    chk("R11 read data", rd_data, 64'h5555_6666_7777_8888);

    // R7 DMA root write
    req(1'b1, 1'b1, 4'd2, 2'd3, 64'h0D0D);
    chk("R7 dma invalidation", {48'h0, atc_valid}, 64'h02);

    // R1 user write to supervisor root leaves the ATC alone
    fill(4'd3, 1'b0, 2'd1, 3'd0);
    req(1'b0, 1'b1, 4'd1, 2'd3, 64'h1);
    chk("R1 user root write trap", {63'h0, priv_trap}, 64'h1);
    chk("R1 atc unchanged", {48'h0, atc_valid}, 64'h0A);
    rd_chk("R1 sup root unchanged", 4'd1, 2'd3, 64'h5555_6666_7777_8888);

    // R5 round-robin wrap
    for (int i = 2; i < 8; i++) begin
      req(1'b1, 1'b1, 4'd0, 2'd3, 64'h1000 + 64'(i));
      chk("R5 round-robin slot", {61'h0, root_slot}, 64'(i));
    end
    fill(4'd8, 1'b0, 2'd0, 3'd0);
    fill(4'd9, 1'b1, 2'd0, 3'd0);
    req(1'b1, 1'b1, 4'd0, 2'd3, 64'h2000);
    chk("R5 wrap to slot 0", {61'h0, root_slot}, 64'h0);
    chk("R5 wrap invalidation spares global", {48'h0, atc_valid}, 64'h20A);
    req(1'b1, 1'b1, 4'd0, 2'd3, 64'hAAAA_0000_0000_0001);
    chk("R5 evicted value misses", {61'h0, root_slot}, 64'h1);

    // R8 / R9 translation control check
    req(1'b1, 1'b1, 4'd3, 2'd2, 64'h80C0_8444);
    chk("R8 good enable no cfg_err", {63'h0, cfg_err}, 64'h0);
    rd_chk("R8 good enable stored", 4'd3, 2'd2, 64'h80C0_8444);
    req(1'b1, 1'b1, 4'd3, 2'd2, 64'h80C0_8445);
    chk("R9 no check when set", {63'h0, cfg_err}, 64'h0);
    rd_chk("R9 stored as written", 4'd3, 2'd2, 64'h80C0_8445);
    req(1'b1, 1'b1, 4'd3, 2'd2, 64'h0);
    req(1'b1, 1'b1, 4'd3, 2'd2, 64'h80C0_8445);
    chk("R8 bad fields cfg_err", {63'h0, cfg_err}, 64'h1);
    rd_chk("R8 enable held clear", 4'd3, 2'd2, 64'h00C0_8445);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule